// File: doc/BRIEF.md
# Light-Load Burst Mode Controller

This block governs the low-power burst operation of a quasi-resonant flyback controller. At light load it watches the feedback comparators and the valley counter. When the load stays low for long enough, it moves the converter into burst mode. In burst mode it switches the power stage in packets at a fixed frequency with a reduced current limit. When a load step pushes the feedback up, it returns the converter to normal quasi-resonant operation.

Every input is a synchronous digital flag from the analog comparators around the block. The valley counter value arrives as a 3-bit binary number. The block drives four outputs:

- a burst-mode flag, which tells the normal PWM to stand down;
- a gate request, used for burst pulses only;
- an enable for the internal bias, which is dropped between burst packets;
- a one-cycle pulse that reseeds the valley counter to 1 when burst mode ends.

Entry blanking is built from a clock prescaler of `TICK_DIV` cycles counted `BLANK_TICKS` times. The defaults give 24 ms at 50 MHz. The burst switching period is `PERIOD_CLKS` system clocks, which is close to 52 kHz at the default. The maximum on-time is `PERIOD_CLKS/2` cycles.

Top module: `bm_ctrl`

## Requirements
- R1: Burst mode is entered only when the low-feedback flag is high and `valley_cnt` equals 7 (binary 3'b111), both on every clock for `TICK_DIV*BLANK_TICKS` consecutive cycles. `burst_mode` rises on the edge that samples the last of those cycles.
- R2: If either entry condition is absent for one clock, the blanking count restarts from zero. A new full window is then needed.
- R3: In burst mode, `bias_en` rises on the edge that samples `fb_above_on` and falls on the edge that samples `fb_below_off`. Outside burst mode, `bias_en` is 1.
- R4: While the burst band is active, the gate turns on once every `PERIOD_CLKS` cycles. The first turn-on happens on the same edge on which the band activates.
- R5: A burst gate pulse lasts at most `PERIOD_CLKS/2` cycles, which is a 50% duty limit.
- R6: `cs_burst_lim` sampled high while the gate is on ends the pulse at the next edge. It is ignored on the turn-on edge.
- R7: `fb_above_exit` sampled high in burst mode clears `burst_mode`, the gate and the band on the next edge.
- R8: Leaving burst mode produces `valley_reset` high for exactly one cycle, on the same edge that clears `burst_mode`.
- R9: After reset, `burst_mode`=0, `gate_req`=0, `valley_reset`=0 and `bias_en`=1.
- R10: Outside burst mode, `gate_req` stays 0 and the band flags `fb_above_on` and `fb_below_off` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fb_low_entry | input | 1 | Feedback below the burst entry level |
| fb_above_on | input | 1 | Feedback above the packet start level |
| fb_below_off | input | 1 | Feedback below the packet stop level |
| fb_above_exit | input | 1 | Feedback above the burst exit level |
| cs_burst_lim | input | 1 | Current sense at the reduced burst limit |
| valley_cnt | input | 3 | Present valley up/down counter value |
| burst_mode | output | 1 | Block is in burst mode |
| gate_req | output | 1 | Burst gate drive request |
| bias_en | output | 1 | Internal bias enable |
| valley_reset | output | 1 | One-cycle pulse forcing the valley counter to 1 |

## Verification
The embedded assertions check several rules on every clock:

- the gate is never requested outside burst mode;
- the valley reseed pulse is one cycle wide and follows every exit;
- the band drops on the stop flag;
- a gate pulse never runs past half a period;
- the blanking counters clear whenever a qualifying condition is missing.

Some behaviour shows only in the bench scenarios, which compare every output each cycle against a behavioural model. These scenarios cover the exact entry latency, the restart of the window after a one-cycle drop, the absolute burst period, the early termination by the current flag, and the indifference to band flags in normal mode.

// File: rtl/bm_pkg.sv
package bm_pkg;
  typedef enum logic {
    MODE_NORMAL = 1'b0,
    MODE_BURST  = 1'b1
  } bm_mode_e;

  localparam int unsigned VALLEY_W   = 3;
  localparam int unsigned VALLEY_TOP = 7;
endpackage

// File: rtl/bm_entry_qual.sv
module bm_entry_qual #(
  parameter int unsigned TICK_DIV    = 50000,
  parameter int unsigned BLANK_TICKS = 24,
  parameter int unsigned VALLEY_W    = 3,
  parameter int unsigned VALLEY_TOP  = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                arm,
  input  logic                fb_low,
  input  logic [VALLEY_W-1:0] valley,
  output logic                enter
);
  localparam int unsigned PRE_W = (TICK_DIV    > 1) ? $clog2(TICK_DIV)    : 1;
  localparam int unsigned BLK_W = (BLANK_TICKS > 1) ? $clog2(BLANK_TICKS) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);
  localparam logic [BLK_W-1:0] BLK_LAST = BLK_W'(BLANK_TICKS - 1);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [BLK_W-1:0] blk_q, blk_d;
  logic             qual, tick;

  always_comb begin
    qual  = arm && fb_low && (valley == VALLEY_W'(VALLEY_TOP));
    tick  = qual && (pre_q == PRE_LAST);
    enter = tick && (blk_q == BLK_LAST);
    pre_d = pre_q;
    blk_d = blk_q;
    if (!qual) begin
      pre_d = '0;
      blk_d = '0;
    end else if (tick) begin
      pre_d = '0;
      blk_d = (blk_q == BLK_LAST) ? '0 : blk_q + 1'b1;
    end else begin
      pre_d = pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      blk_q <= '0;
    end else begin
      pre_q <= pre_d;
      blk_q <= blk_d;
    end
  end

  // R2: a missing condition restarts the whole window
  p_window_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !qual |=> (pre_q == '0 && blk_q == '0));
  // R1: entry only while qualified
  p_entry_qualified_r1: assert property (@(posedge clk) disable iff (!rst_n)
    enter |-> (fb_low && arm && valley == VALLEY_W'(VALLEY_TOP)));
endmodule

// File: rtl/bm_band.sv
module bm_band (
  input  logic clk,
  input  logic rst_n,
  input  logic stay_burst,
  input  logic on_flag,
  input  logic off_flag,
  output logic active_d,
  output logic active_q
);
  always_comb begin
    if (!stay_burst)   active_d = 1'b0;
    else if (active_q) active_d = !off_flag;
    else               active_d = on_flag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active_q <= 1'b0;
    else        active_q <= active_d;
  end

  // R3: stop flag ends the packet
  p_band_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && off_flag) |=> !active_q);
  // R3: start flag opens the packet while burst persists
  p_band_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stay_burst && !active_q && on_flag) |=> active_q);
endmodule

// File: rtl/bm_pwm.sv
module bm_pwm #(
  parameter int unsigned PERIOD_CLKS = 962
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_d,
  input  logic cs_lim,
  output logic gate
);
  localparam int unsigned HALF  = PERIOD_CLKS / 2;
  localparam int unsigned PH_W  = $clog2(PERIOD_CLKS);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PERIOD_CLKS - 1);
  localparam logic [PH_W-1:0] PH_HALF = PH_W'(HALF);

  logic [PH_W-1:0] ph_q, ph_d;
  logic            gate_q, gate_d;

  always_comb begin
    if (!run_d)               ph_d = '0;
    else if (ph_q == PH_LAST) ph_d = '0;
    else                      ph_d = ph_q + 1'b1;

    if (!run_d)             gate_d = 1'b0;
    else if (ph_q == '0)    gate_d = 1'b1;
    else                    gate_d = gate_q && !cs_lim && (ph_q < PH_HALF);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= '0;
      gate_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      gate_q <= gate_d;
    end
  end

  assign gate = gate_q;

  // R5: gate is never high beyond half the period
  p_max_duty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    gate_q |-> (ph_q != '0 && ph_q <= PH_HALF));
  // R6: current flag during a pulse ends it
  p_cs_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_q && cs_lim && ph_q != '0) |=> !gate_q);
  // R4: a pulse begins at the start of a period
  p_pulse_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_q) |-> (ph_q == PH_W'(1)));
endmodule

// File: rtl/bm_ctrl.sv
module bm_ctrl #(
  parameter int unsigned TICK_DIV    = 50000,
  parameter int unsigned BLANK_TICKS = 24,
  parameter int unsigned PERIOD_CLKS = 962
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fb_low_entry,
  input  logic       fb_above_on,
  input  logic       fb_below_off,
  input  logic       fb_above_exit,
  input  logic       cs_burst_lim,
  input  logic [2:0] valley_cnt,
  output logic       burst_mode,
  output logic       gate_req,
  output logic       bias_en,
  output logic       valley_reset
);
  import bm_pkg::*;

  bm_mode_e mode_q, mode_d;
  logic     vres_q, vres_d;
  logic     enter, stay_burst, act_d, act_q, gate;

  bm_entry_qual #(
    .TICK_DIV   (TICK_DIV),
    .BLANK_TICKS(BLANK_TICKS),
    .VALLEY_W   (VALLEY_W),
    .VALLEY_TOP (VALLEY_TOP)
  ) u_entry (
    .clk   (clk),
    .rst_n (rst_n),
    .arm   (mode_q == MODE_NORMAL),
    .fb_low(fb_low_entry),
    .valley(valley_cnt),
    .enter (enter)
  );

  always_comb begin
    stay_burst = (mode_q == MODE_BURST) && !fb_above_exit;
    vres_d     = (mode_q == MODE_BURST) && fb_above_exit;
    mode_d     = mode_q;
    if (mode_q == MODE_NORMAL) begin
      if (enter) mode_d = MODE_BURST;
    end else if (fb_above_exit) begin
      mode_d = MODE_NORMAL;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_NORMAL;
      vres_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      vres_q <= vres_d;
    end
  end

  bm_band u_band (
    .clk       (clk),
    .rst_n     (rst_n),
    .stay_burst(stay_burst),
    .on_flag   (fb_above_on),
    .off_flag  (fb_below_off),
    .active_d  (act_d),
    .active_q  (act_q)
  );

  bm_pwm #(.PERIOD_CLKS(PERIOD_CLKS)) u_pwm (
    .clk   (clk),
    .rst_n (rst_n),
    .run_d (act_d),
    .cs_lim(cs_burst_lim),
    .gate  (gate)
  );

  assign burst_mode   = (mode_q == MODE_BURST);
  assign gate_req     = gate;
  assign bias_en      = (mode_q == MODE_NORMAL) || act_q;
  assign valley_reset = vres_q;

  // R10: no burst gate outside burst mode
  p_gate_in_burst_r10: assert property (@(posedge clk) disable iff (!rst_n)
    gate_req |-> burst_mode);
  // R7: exit flag leaves burst at once
  p_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_mode && fb_above_exit) |=> (!burst_mode && !gate_req));
  // R8: reseed pulse follows every exit and lasts one cycle
  p_reseed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(burst_mode) |-> valley_reset);
  p_reseed_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valley_reset |=> !valley_reset);
endmodule

// File: tb/bm_ctrl_bench.sv
module bm_ctrl_bench;
  localparam int TD = 4;
  localparam int BT = 3;
  localparam int P  = 10;
  localparam int H  = P / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fb_lo = 0, fb_on = 0, fb_off = 0, fb_ex = 0, cs = 0;
  logic [2:0] vcnt = 3'd0;
  logic burst_mode, gate_req, bias_en, valley_reset;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;

  // reference model state
  int m_pre = 0, m_blk = 0, m_burst = 0, m_act = 0, m_ph = 0, m_g = 0, m_vr = 0;

  always #10 clk = ~clk;

  bm_ctrl #(.TICK_DIV(TD), .BLANK_TICKS(BT), .PERIOD_CLKS(P)) u_bm_ctrl (
    .clk(clk), .rst_n(rst_n),
    .fb_low_entry(fb_lo), .fb_above_on(fb_on), .fb_below_off(fb_off),
    .fb_above_exit(fb_ex), .cs_burst_lim(cs), .valley_cnt(vcnt),
    .burst_mode(burst_mode), .gate_req(gate_req), .bias_en(bias_en),
    .valley_reset(valley_reset)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // behavioural model: advances with the clock per the requirements
  always @(posedge clk) begin
    if (rst_n) begin
      bit q, ent, stay;
      int n_act, n_ph, n_g;
      cyc++;
      q    = !m_burst && fb_lo && vcnt == 3'd7;
      ent  = q && m_pre == TD-1 && m_blk == BT-1;
      stay = m_burst && !fb_ex;
      n_act = stay ? (m_act ? !fb_off : fb_on) : 0;
      n_ph  = n_act ? ((m_ph + 1) % P) : 0;
      n_g   = n_act && (m_ph == 0 || (m_g && !cs && m_ph < H));
      m_vr  = m_burst && fb_ex;
      if (!q) begin m_pre = 0; m_blk = 0; end
      else if (m_pre == TD-1) begin m_pre = 0; m_blk = (m_blk + 1) % BT; end
      else m_pre++;
      m_burst = m_burst ? !fb_ex : ent;
      m_act = n_act; m_ph = n_ph; m_g = n_g;
    end
  end

  // lockstep comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check(burst_mode == m_burst, "R1/R7 burst_mode", burst_mode, m_burst);
      check(gate_req == m_g, "R4/R5/R6 gate_req", gate_req, m_g);
      check(bias_en == (!m_burst || m_act), "R3 bias_en", bias_en, (!m_burst || m_act));
      check(valley_reset == m_vr, "R8 valley_reset", valley_reset, m_vr);
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
    end
  endtask

  initial begin
    int waited, highs;
    step(3);
    check(burst_mode == 0 && gate_req == 0 && bias_en == 1 && valley_reset == 0,
          "R9 reset state", {burst_mode, gate_req, bias_en, valley_reset}, 4'b0010);
    rst_n = 1'b1;

    // R10: band flags in normal mode have no effect
    fb_on = 1; step(3); fb_on = 0;
    check(gate_req == 0 && bias_en == 1, "R10 band flags ignored", {gate_req, bias_en}, 2'b01);

    // R1: valley not at 7 never enters
    fb_lo = 1; vcnt = 3'd6; step(30);
    check(burst_mode == 0, "R1 no entry with valley 6", burst_mode, 0);

    // R2: drop after 8 cycles restarts the window
    vcnt = 3'd7; step(8);
    fb_lo = 0; step(1); fb_lo = 1;
    waited = 0;
    while (!burst_mode && waited < 100) begin step(1); waited++; end
    check(waited == TD*BT, "R2/R1 entry latency after restart", waited, TD*BT);
    check(bias_en == 0, "R3 bias off on burst entry", bias_en, 0);

    // R4/R5: packet starts, 50% duty over a full period
    fb_lo = 0; fb_on = 1; step(1); fb_on = 0;
    check(gate_req == 1 && bias_en == 1, "R4 gate on at band start", {gate_req, bias_en}, 2'b11);
    step(3);
    highs = 0;
    for (int i = 0; i < P; i++) begin step(1); highs += gate_req; end
    check(highs == H, "R5 duty over one period", highs, H);

    // R6: current flag cuts a pulse short
    while (gate_req) step(1);
    while (!gate_req) step(1);
    step(1); cs = 1; step(1); cs = 0;
    check(gate_req == 0, "R6 cs ends pulse", gate_req, 0);
    step(12);

    // R3: stop flag drops bias and gate
    fb_off = 1; step(1); fb_off = 0;
    check(bias_en == 0 && gate_req == 0, "R3 band stop", {bias_en, gate_req}, 2'b00);
    step(4);
    fb_on = 1; step(1); fb_on = 0; step(2);

    // R7/R8: exit
    fb_ex = 1; step(1); fb_ex = 0;
    check(burst_mode == 0 && gate_req == 0, "R7 exit", {burst_mode, gate_req}, 2'b00);
    check(valley_reset == 1, "R8 reseed pulse", valley_reset, 1);
    step(1);
    check(valley_reset == 0 && bias_en == 1, "R8 pulse one cycle", {valley_reset, bias_en}, 2'b01);
    step(5);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule